// File: doc/BRIEF.md
# Iterative Multiply/Divide Unit with HI/LO Result Pair

This block performs 32-bit integer multiplication and division over many clock cycles and leaves its results in a pair of 32-bit result registers, HI and LO. A one-cycle `start` pulse carries an operation code and two operands. Multiplication adds the multiplicand into a partial product under control of each multiplier bit and shifts, one bit per cycle. Division shifts the partial remainder left and attempts a subtraction, producing one quotient bit per cycle and keeping the old remainder when the attempt borrows.

Signed operations convert both operands to magnitudes and run the unsigned core. At the end they negate the product or quotient when the operand signs differ, and give the remainder the dividend's sign. A division never signals an error. A zero divisor simply produces what the core computes.

The controller has three states. `ST_IDLE` waits for work, and the transition *accept* (`start` high) leaves it. `ST_SETUP` loads the core with the magnitudes; the transition *launch* always follows after one cycle. `ST_ITER` runs one step per cycle. It keeps itself through the transition *step* and returns to `ST_IDLE` through the transition *finish* after the last step. On *finish*, HI and LO are written and `done` rises for one cycle. HI and LO may be read at any time.

Top module: `muldiv_hilo`

## Requirements
- R1: While `rst_n` is low and after its release, `busy` and `done` are 0 and `hi` and `lo` are 0 until an operation completes.
- R2: With `op` = 2'b01 (unsigned multiply), the 64-bit unsigned product of `opa` and `opb` is written with bits 63:32 in `hi` and bits 31:0 in `lo`.
- R3: With `op` = 2'b00 (signed multiply), the 64-bit two's-complement product of `opa` and `opb` is written with bits 63:32 in `hi` and bits 31:0 in `lo`.
- R4: With `op` = 2'b11 (unsigned divide) and a nonzero `opb`, `lo` receives `opa / opb` and `hi` receives `opa % opb`.
- R5: With `op` = 2'b10 (signed divide) and a nonzero `opb`, `lo` receives the quotient truncated toward zero and `hi` receives the remainder with the dividend's sign. For 0x80000000 divided by 0xFFFFFFFF, the quotient is 0x80000000 and the remainder is 0.
- R6: With `opb` = 0, a division raises no indication. `hi` equals `opa`. `lo` is 0xFFFFFFFF, except for a signed divide of a negative `opa`, where it is 0x00000001.
- R7: A `start` seen in an idle cycle makes `busy` high from the next cycle for exactly 33 consecutive cycles.
- R8: `done` is high for exactly one cycle, the first cycle after `busy` falls, and at no other time.
- R9: A `start` seen while `busy` is high is ignored. The running operation's results and timing are unchanged, and a `start` in the `done` cycle is accepted.
- R10: `hi` and `lo` change only in the cycle where `done` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a new operation |
| op | input | 2 | Operation: 00 signed mul, 01 unsigned mul, 10 signed div, 11 unsigned div |
| opa | input | 32 | Multiplicand or dividend |
| opb | input | 32 | Multiplier or divisor |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| hi | output | 32 | Product upper half or remainder |
| lo | output | 32 | Product lower half or quotient |

## Verification
The assertions assume that `start` is a plain synchronous level. They make no assumption about how `start` relates to `busy`, so a start during a run is legal input. The stimulus therefore drives `start` while the unit is running, and also holds it high across a whole run so that it lands in the `done` cycle. Operands are sampled only on acceptance, so the bench changes `opa`, `opb` and `op` freely while busy to show that they have no effect. Corner operands are chosen deliberately: the most negative value, minus one, and a zero divisor of either signedness.

// File: rtl/md_pkg.sv
package md_pkg;
    typedef enum logic [1:0] {
        OP_MULS = 2'b00,
        OP_MULU = 2'b01,
        OP_DIVS = 2'b10,
        OP_DIVU = 2'b11
    } md_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_SETUP = 2'b01,
        ST_ITER  = 2'b10
    } md_state_e;
endpackage

// File: rtl/md_ctrl.sv
module md_ctrl
    import md_pkg::*;
#(
    parameter int ITERS = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic accept,
    output logic load,
    output logic step,
    output logic finish,
    output logic busy
);
    localparam int CW = (ITERS > 1) ? $clog2(ITERS) : 1;

    md_state_e state, state_nxt;
    logic [CW-1:0] cnt;
    logic last;

    assign last = (cnt == CW'(ITERS - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nxt;
            if (state == ST_ITER) cnt <= cnt + 1'b1;
            else                  cnt <= '0;
        end
    end

    // transitions: accept, launch, step, finish
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:  if (start) state_nxt = ST_SETUP;
            ST_SETUP: state_nxt = ST_ITER;
            ST_ITER:  if (last) state_nxt = ST_IDLE;
            default:  state_nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        accept = 1'b0;
        load   = 1'b0;
        step   = 1'b0;
        finish = 1'b0;
        busy   = 1'b0;
        unique case (state)
            ST_IDLE:  accept = start;
            ST_SETUP: begin load = 1'b1; busy = 1'b1; end
            ST_ITER:  begin step = 1'b1; busy = 1'b1; finish = last; end
            default:  ;
        endcase
    end
endmodule

// File: rtl/md_core.sv
module md_core #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic         is_div,
    input  logic [W-1:0] a_mag,
    input  logic [W-1:0] b_mag,
    output logic [W-1:0] nxt_hi,
    output logic [W-1:0] nxt_lo
);
    localparam int DW = 2 * W;

    logic [DW-1:0] acc, acc_nxt;
    logic [W-1:0]  opnd;
    logic [W:0]    sum, rsh, trial;

    always_comb begin
        // multiply: conditional add into upper half, then shift right
        sum   = {1'b0, acc[DW-1:W]} + (acc[0] ? {1'b0, opnd} : '0);
        // divide: shift remainder/quotient left, try subtracting divisor
        rsh   = {acc[DW-1:W], acc[W-1]};
        trial = rsh - {1'b0, opnd};
        if (is_div) begin
            if (trial[W]) acc_nxt = {rsh[W-1:0], acc[W-2:0], 1'b0};
            else          acc_nxt = {trial[W-1:0], acc[W-2:0], 1'b1};
        end else begin
            acc_nxt = {sum, acc[W-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc  <= '0;
            opnd <= '0;
        end else if (load) begin
            acc  <= {{W{1'b0}}, (is_div ? a_mag : b_mag)};
            opnd <= is_div ? b_mag : a_mag;
        end else if (step) begin
            acc  <= acc_nxt;
        end
    end

    assign nxt_hi = acc_nxt[DW-1:W];
    assign nxt_lo = acc_nxt[W-1:0];
endmodule

// File: rtl/md_fix.sv
module md_fix #(
    parameter int W = 32
) (
    input  logic         is_div,
    input  logic         neg_res,
    input  logic         neg_rem,
    input  logic [W-1:0] raw_hi,
    input  logic [W-1:0] raw_lo,
    output logic [W-1:0] fix_hi,
    output logic [W-1:0] fix_lo
);
    logic [2*W-1:0] prod_neg;

    assign prod_neg = -{raw_hi, raw_lo};

    always_comb begin
        if (is_div) begin
            fix_lo = neg_res ? -raw_lo : raw_lo;
            fix_hi = neg_rem ? -raw_hi : raw_hi;
        end else if (neg_res) begin
            fix_hi = prod_neg[2*W-1:W];
            fix_lo = prod_neg[W-1:0];
        end else begin
            fix_hi = raw_hi;
            fix_lo = raw_lo;
        end
    end
endmodule

// File: rtl/muldiv_hilo.sv
module muldiv_hilo
    import md_pkg::*;
#(
    parameter int W     = 32,
    parameter int ITERS = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [1:0]   op,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] hi,
    output logic [W-1:0] lo
);
    logic         accept, load, step, finish;
    md_op_e       op_q;
    logic [W-1:0] a_q, b_q, a_mag, b_mag;
    logic         sgn, is_div, a_neg, b_neg;
    logic [W-1:0] raw_hi, raw_lo, fix_hi, fix_lo;

    md_ctrl #(.ITERS(ITERS)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start),
        .accept(accept), .load(load), .step(step),
        .finish(finish), .busy(busy)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q <= OP_MULU;
            a_q  <= '0;
            b_q  <= '0;
        end else if (accept) begin
            op_q <= md_op_e'(op);
            a_q  <= opa;
            b_q  <= opb;
        end
    end

    assign is_div = (op_q == OP_DIVS) || (op_q == OP_DIVU);
    assign sgn    = (op_q == OP_MULS) || (op_q == OP_DIVS);
    assign a_neg  = sgn & a_q[W-1];
    assign b_neg  = sgn & b_q[W-1];
    assign a_mag  = a_neg ? -a_q : a_q;
    assign b_mag  = b_neg ? -b_q : b_q;

    md_core #(.W(W)) u_core (
        .clk(clk), .rst_n(rst_n), .load(load), .step(step),
        .is_div(is_div), .a_mag(a_mag), .b_mag(b_mag),
        .nxt_hi(raw_hi), .nxt_lo(raw_lo)
    );

    md_fix #(.W(W)) u_fix (
        .is_div(is_div), .neg_res(a_neg ^ b_neg), .neg_rem(a_neg),
        .raw_hi(raw_hi), .raw_lo(raw_lo),
        .fix_hi(fix_hi), .fix_lo(fix_lo)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi   <= '0;
            lo   <= '0;
            done <= 1'b0;
        end else begin
            done <= finish;
            if (finish) begin
                hi <= fix_hi;
                lo <= fix_lo;
            end
        end
    end
endmodule

// File: rtl/md_checker.sv
module md_checker #(
    parameter int W     = 32,
    parameter int ITERS = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         busy,
    input logic         done,
    input logic [W-1:0] hi,
    input logic [W-1:0] lo
);
    localparam int RUN = ITERS + 1;
    localparam int RW  = $clog2(RUN + 2) + 1;

    logic [RW-1:0] run_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      run_len <= '0;
        else if (!busy)  run_len <= '0;
        else             run_len <= run_len + 1'b1;
    end

    AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy); // R7
    AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && run_len != '0) |-> (run_len == RW'(RUN))); // R7
    AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_len < RW'(RUN))); // R7
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && run_len == RW'(RUN))); // R8
    AST_HILO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(hi) && $stable(lo))); // R10
endmodule

bind muldiv_hilo md_checker #(.W(W), .ITERS(ITERS)) u_md_checker (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
    .done(done), .hi(hi), .lo(lo)
);

// File: tb/tb_muldiv_hilo.sv
module tb_muldiv_hilo;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  op = 2'b00;
    logic [31:0] opa = '0, opb = '0;
    logic        busy, done;
    logic [31:0] hi, lo;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    bit fin     = 1'b0;

    // reference model state
    int          m_cnt  = 0;
    logic        m_done = 1'b0;
    logic [31:0] m_hi = '0, m_lo = '0;
    logic [63:0] m_pend = '0;
    string       m_tag = "R10", p_tag = "R10";

    always #4 clk = ~clk;

    muldiv_hilo dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op),
        .opa(opa), .opb(opb), .busy(busy), .done(done),
        .hi(hi), .lo(lo)
    );

    // returns {hi, lo}
    function automatic logic [63:0] ref_calc(logic [1:0] o, logic [31:0] a, logic [31:0] b);
        logic [63:0] p;
        logic [31:0] q, r;
        longint sa, sb;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        p = '0; q = '0; r = '0;
        case (o)
            2'b00: p = sa * sb;
            2'b01: p = {32'b0, a} * {32'b0, b};
            2'b10: begin
                if (b == 0) begin q = a[31] ? 32'h1 : 32'hFFFF_FFFF; r = a; end
                else begin q = 32'(sa / sb); r = 32'(sa % sb); end
                p = {r, q};
            end
            default: begin
                if (b == 0) begin q = 32'hFFFF_FFFF; r = a; end
                else begin q = a / b; r = a % b; end
                p = {r, q};
            end
        endcase
        return p;
    endfunction

    function automatic string tag_of(logic [1:0] o, logic [31:0] b);
        if (o[1] && b == 0) return "R6";
        case (o)
            2'b00:   return "R3";
            2'b01:   return "R2";
            2'b10:   return "R5";
            default: return "R4";
        endcase
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            m_cnt <= 0; m_done <= 1'b0; m_hi <= '0; m_lo <= '0;
        end else if (m_cnt == 0) begin
            m_done <= 1'b0;
            if (start) begin
                m_cnt  <= 33;
                m_pend <= ref_calc(op, opa, opb);
                p_tag  <= tag_of(op, opb);
            end
        end else begin
            m_cnt  <= m_cnt - 1;
            m_done <= (m_cnt == 1);
            if (m_cnt == 1) begin
                m_hi  <= m_pend[63:32];
                m_lo  <= m_pend[31:0];
                m_tag <= p_tag;
            end
        end
    end

    task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // compare against the model every cycle
    always @(negedge clk) begin
        if (!fin) begin
            chk(busy === (m_cnt != 0), rst_n ? "R7" : "R1", {63'b0, busy}, {63'b0, m_cnt != 0});
            chk(done === m_done, rst_n ? "R8" : "R1", {63'b0, done}, {63'b0, m_done});
            chk({hi, lo} === {m_hi, m_lo}, !rst_n ? "R1" : (m_done ? m_tag : "R10"),
                {hi, lo}, {m_hi, m_lo});
        end
    end

    task automatic finish_run();
        fin = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cyc > 150000 && !fin) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: run did not finish actual=%0d expected=<150000", cyc);
            finish_run();
        end
    end

    task automatic wait_idle();
        @(negedge clk);
        while (m_cnt != 0) @(negedge clk);
    endtask

    task automatic run_op(logic [1:0] o, logic [31:0] a, logic [31:0] b);
        @(negedge clk);
        op = o; opa = a; opb = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        op = ~o; opa = ~a; opb = b ^ 32'h5A5A_0001; // no effect while busy
        wait_idle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(busy === 1'b0 && done === 1'b0 && hi === '0 && lo === '0, "R1",
            {hi, lo}, 64'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(busy === 1'b0 && hi === '0 && lo === '0, "R1", {hi, lo}, 64'h0);

        // R2 unsigned multiply
        run_op(2'b01, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        run_op(2'b01, 32'h1234_5678, 32'h9ABC_DEF0);
        run_op(2'b01, 32'h0, 32'hDEAD_BEEF);
        // R3 signed multiply
        run_op(2'b00, 32'hFFFF_FFFF, 32'h0000_0005);
        run_op(2'b00, 32'h8000_0000, 32'h8000_0000);
        run_op(2'b00, 32'h8000_0000, 32'hFFFF_FFFF);
        run_op(2'b00, 32'h7FFF_FFFF, 32'h8000_0001);
        // R4 unsigned divide
        run_op(2'b11, 32'd100, 32'd7);
        run_op(2'b11, 32'hFFFF_FFFF, 32'h1);
        run_op(2'b11, 32'h5, 32'h9);
        // R5 signed divide
        run_op(2'b10, 32'hFFFF_FF9C, 32'd7);    // -100 / 7
        run_op(2'b10, 32'd100, 32'hFFFF_FFF9);  // 100 / -7
        run_op(2'b10, 32'h8000_0000, 32'hFFFF_FFFF);
        chk(lo === 32'h8000_0000 && hi === 32'h0, "R5", {hi, lo}, 64'h8000_0000);
        // R6 zero divisor
        run_op(2'b11, 32'hCAFE_0001, 32'h0);
        chk(lo === 32'hFFFF_FFFF && hi === 32'hCAFE_0001, "R6", {hi, lo}, 64'hCAFE_0001_FFFF_FFFF);
        run_op(2'b10, 32'hFFFF_FFF0, 32'h0);
        chk(lo === 32'h1 && hi === 32'hFFFF_FFF0, "R6", {hi, lo}, 64'hFFFF_FFF0_0000_0001);
        run_op(2'b10, 32'h0000_0042, 32'h0);

        // random mix
        for (int i = 0; i < 24; i++)
            run_op(2'($urandom), $urandom, (i % 6 == 5) ? 32'h0 : $urandom);

        // R9: start pulses during a run are ignored
        @(negedge clk);
        op = 2'b01; opa = 32'd3; opb = 32'd5; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        op = 2'b11; opa = 32'd77; opb = 32'd2; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_idle();
        chk(hi === 32'h0 && lo === 32'd15, "R9", {hi, lo}, 64'd15);

        // R9: start held high through a run; re-accepted in the done cycle
        @(negedge clk);
        op = 2'b00; opa = 32'hFFFF_FFFE; opb = 32'd3; start = 1'b1;
        repeat (36) @(negedge clk);
        chk(m_cnt != 0 && busy === 1'b1, "R9", {63'b0, busy}, 64'd1);
        start = 1'b0;
        wait_idle();
        chk(hi === 32'hFFFF_FFFF && lo === 32'hFFFF_FFFA, "R9", {hi, lo}, 64'hFFFF_FFFF_FFFF_FFFA);

        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule